// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is a target-only two-wire serial bus interface for a small sensor-style register file. The SCL and SDA pins are sampled by the system clock. Each line passes through a synchronizer and a majority-vote filter. The block finds START and STOP conditions and shifts in bytes on rising SCL edges. It acknowledges by asserting an open-drain pull-down enable on SDA. Its 7-bit bus address is `1001_0xy`, where `xy` comes from a two-bit strap input. Up to four such blocks can therefore share one bus.

Every write transaction starts with a pointer byte that selects one of four 16-bit registers:

- a read-only temperature word taken from an input port;
- a configuration word;
- a low limit;
- a high limit.

Up to two data bytes may follow the pointer. They are stored high byte first. Reads carry no register address. A read returns the register chosen by the last written pointer. A host that wants a different register must first send a pointer-only write and then start a separate read.

Top module: `tsense_i2c_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0. `thi_o` is 16'h5000 (+80 C at 1/16 C per LSB, 12-bit left-justified). `tlo_o` is 16'h4B00 (+75 C). `cfg_o` is 16'h0000. The pointer is 0.
- R2: The block responds only to address byte `{5'b10010, strap_i, rw}`, where rw is bit 0. If the address does not match, the block gives no acknowledge and drives nothing until the next START.
- R3: After a matching address byte, and after each pointer or data byte of a write, the block holds SDA low (`sda_oe_o`=1) through the 9th SCL clock.
- R4: Bits [1:0] of the pointer byte select the register: 00 is the temperature input, 01 is configuration, 10 is the low limit and 11 is the high limit. The pointer keeps its value across transactions.
- R5: In a write, the first data byte after the pointer becomes bits [15:8] and the second becomes bits [7:0]. The register updates only when the second byte completes. Any further bytes are acknowledged and discarded.
- R6: A write that carries only the pointer byte changes the pointer and leaves every register unchanged.
- R7: A read returns the register selected by the pointer, high byte first, each byte MSB first. The word is captured when the first byte starts.
- R8: Writes with pointer 00 are acknowledged and have no effect. Reads of pointer 00 return `temp_i`.
- R9: If the host answers a read byte with NACK, the block leaves SDA released until the next START.
- R10: A STOP ends the transaction at any point. If it comes before the second data byte completes, no register changes. A repeated START begins a new address phase and keeps the pointer.
- R11: An SDA pulse of one system clock while SCL is high is filtered out. It is taken neither as a START/STOP nor as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Address strap, low two bits of the bus address |
| temp_i | input | 16 | Temperature word served at pointer 00 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | 16 | Configuration register |
| tlo_o | output | 16 | Low limit register |
| thi_o | output | 16 | High limit register |

## Verification
Two kinds of event compete in the sequencer: a bus condition (START or STOP) and the byte handling it cuts short. The bench provokes this in two ways. It sends a STOP right after the first data byte of a write. It also sends a repeated START directly after a pointer byte. The block is judged correct when the partial write leaves the register unchanged and the new address phase is acknowledged with the old pointer still in force. A second case uses a one-clock SDA glitch while SCL is high, in the middle of a data bit. The glitch could look like both a bus condition and a data edge. The bench checks that the write still completes with the intended value.

// File: rtl/tsi_pkg.sv
// Shared types for the two-wire sensor register slave.
package tsi_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
        S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK, S_IGNORE
    } bus_state_t;

    localparam logic [1:0] PTR_TEMP = 2'd0;
    localparam logic [1:0] PTR_CFG  = 2'd1;
    localparam logic [1:0] PTR_TLO  = 2'd2;
    localparam logic [1:0] PTR_THI  = 2'd3;
endpackage

// File: rtl/tsi_line_filter.sv
// Conditions one bus line.
// The line passes through a synchronizer chain and then a majority vote over
// the last VOTE_LEN samples, so it is held high through reset.
// Assumes: SYNC_STAGES >= 2, VOTE_LEN odd and >= 3.
module tsi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int HALF = VOTE_LEN / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_LEN-1:0]    win_q;

    // Synchronize the line and keep a window of recent samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            win_q  <= {win_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
            filt_o <= ($countones(win_q) > HALF);
        end
    end

    // A change of the filtered line needs the newest sample to agree with it (R11).
    p_vote_agree_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(win_q[0]) == filt_o));
endmodule

// File: rtl/tsi_bus_ctrl.sv
// Byte-level sequencer for the two-wire bus.
// It finds START/STOP, matches the address, loads the pointer, assembles write
// data, serializes read data and drives the acknowledge.
// Assumes: filtered inputs, with SCL at least 16x slower than clk.
module tsi_bus_ctrl
    import tsi_pkg::*;
#(
    parameter int          DW      = 16,
    parameter logic [4:0]  ADDR_HI = 5'b10010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [1:0]    strap,
    input  logic [DW-1:0] rd_word,
    output logic          drive,
    output logic [1:0]    ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_word
);
    localparam int BW = DW / 2;

    bus_state_t     st;
    logic           scl_q, sda_q, rw, nack, rbyte;
    logic [3:0]     cnt;
    logic [1:0]     nbytes;
    logic [BW-1:0]  sh, tx, hold, lo_b;
    logic           scl_rise, scl_fall, start_det, stop_det;

    // Edge and bus-condition detection on the filtered lines.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end

    // Main sequencer: conditions first, then rising-edge sampling, then falling-edge actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; drive <= 1'b0;
            rw <= 1'b0; nack <= 1'b0; rbyte <= 1'b0; cnt <= '0; nbytes <= '0;
            sh <= '0; tx <= '0; hold <= '0; lo_b <= '0; ptr <= PTR_TEMP;
            wr_en <= 1'b0; wr_word <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wr_en <= 1'b0;
            if (start_det) begin
                st <= S_ADDR; cnt <= '0; drive <= 1'b0;
            end else if (stop_det) begin
                st <= S_IDLE; drive <= 1'b0;
            end else if (scl_rise) begin
                case (st)
                    S_ADDR, S_PTR, S_WDAT: begin
                        sh  <= {sh[BW-2:0], sda_f};
                        cnt <= cnt + 4'd1;
                    end
                    S_RDAT:  cnt  <= cnt + 4'd1;
                    S_RACK:  nack <= sda_f;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st)
                    S_ADDR: if (cnt == 4'd8) begin
                        if (sh[7:1] == {ADDR_HI, strap}) begin
                            drive <= 1'b1; rw <= sh[0]; st <= S_ADDR_ACK;
                        end else begin
                            st <= S_IGNORE;
                        end
                    end
                    S_ADDR_ACK: begin
                        cnt <= '0;
                        if (rw) begin
                            tx <= rd_word[DW-1:BW]; lo_b <= rd_word[BW-1:0];
                            drive <= ~rd_word[DW-1]; rbyte <= 1'b0; st <= S_RDAT;
                        end else begin
                            drive <= 1'b0; st <= S_PTR;
                        end
                    end
                    S_PTR: if (cnt == 4'd8) begin
                        ptr <= sh[1:0]; drive <= 1'b1; st <= S_PTR_ACK;
                    end
                    S_PTR_ACK: begin
                        drive <= 1'b0; cnt <= '0; nbytes <= '0; st <= S_WDAT;
                    end
                    S_WDAT: if (cnt == 4'd8) begin
                        drive <= 1'b1; st <= S_WDAT_ACK;
                        if (nbytes == 2'd0) hold <= sh;
                        if (nbytes == 2'd1) begin
                            wr_en <= 1'b1; wr_word <= {hold, sh};
                        end
                        if (nbytes != 2'd2) nbytes <= nbytes + 2'd1;
                    end
                    S_WDAT_ACK: begin
                        drive <= 1'b0; cnt <= '0; st <= S_WDAT;
                    end
                    S_RDAT: if (cnt == 4'd8) begin
                        drive <= 1'b0; st <= S_RACK;
                    end else begin
                        tx <= {tx[BW-2:0], 1'b0}; drive <= ~tx[BW-2];
                    end
                    S_RACK: begin
                        cnt <= '0;
                        if (nack) begin
                            st <= S_IGNORE;
                        end else if (!rbyte) begin
                            tx <= lo_b; drive <= ~lo_b[BW-1]; rbyte <= 1'b1; st <= S_RDAT;
                        end else begin
                            tx <= rd_word[DW-1:BW]; lo_b <= rd_word[BW-1:0];
                            drive <= ~rd_word[DW-1]; rbyte <= 1'b0; st <= S_RDAT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Nothing is driven while idle or while ignoring the bus (R2, R9).
    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE || st == S_IGNORE) |-> !drive);
    // The SDA drive holds steady while SCL stays high (R3).
    p_sda_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && scl_q && $past(scl_f)) |-> $stable(drive));
    // A STOP always returns the sequencer to idle (R10).
    p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == S_IDLE));
    // A register commit comes with the acknowledge of its second byte (R5).
    p_commit_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (drive && st == S_WDAT_ACK));
endmodule

// File: rtl/tsi_regs.sv
// The four-entry register file.
// Entry 0 is the temperature input (read-only). Entries 1..3 are writable
// storage with parameterized reset values. The read port is combinational
// on the pointer.
module tsi_regs
    import tsi_pkg::*;
#(
    parameter int          DW      = 16,
    parameter logic [15:0] CFG_RST = 16'h0000,
    parameter logic [15:0] TLO_RST = 16'h4B00,
    parameter logic [15:0] THI_RST = 16'h5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    ptr,
    input  logic [DW-1:0] wr_word,
    input  logic [DW-1:0] temp_word,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] tlo_q,
    output logic [DW-1:0] thi_q
);
    localparam int NREG = 4;

    logic [DW-1:0] regs [NREG];

    function automatic logic [DW-1:0] rst_val(input int idx);
        case (idx)
            1:       return DW'(CFG_RST);
            2:       return DW'(TLO_RST);
            default: return DW'(THI_RST);
        endcase
    endfunction

    assign regs[0] = temp_word;

    for (genvar g = 1; g < NREG; g++) begin : g_store
        // Writable entry g: loaded when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                              regs[g] <= rst_val(g);
            else if (wr_en && ptr == 2'(g))          regs[g] <= wr_word;
        end
    end

    // Read mux and named outputs.
    always_comb begin
        rd_word = regs[ptr];
        cfg_q   = regs[PTR_CFG];
        tlo_q   = regs[PTR_TLO];
        thi_q   = regs[PTR_THI];
    end

    // Writes aimed at the read-only entry change no storage (R8).
    p_ro_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == PTR_TEMP) |=> ($stable(cfg_q) && $stable(tlo_q) && $stable(thi_q)));
    // Without a commit the storage holds (R6).
    p_hold_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_q) && $stable(tlo_q) && $stable(thi_q)));
endmodule

// File: rtl/tsense_i2c_slave.sv
// Top of the two-wire sensor register slave.
// It filters both bus lines, runs the byte sequencer and holds the register
// file. SDA is open-drain: sda_oe_o = 1 pulls the line low.
module tsense_i2c_slave #(
    parameter int          DW          = 16,
    parameter int          SYNC_STAGES = 2,
    parameter int          VOTE_LEN    = 3,
    parameter logic [4:0]  ADDR_HI     = 5'b10010,
    parameter logic [15:0] CFG_RST     = 16'h0000,
    parameter logic [15:0] TLO_RST     = 16'h4B00,
    parameter logic [15:0] THI_RST     = 16'h5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [1:0]    strap_i,
    input  logic [DW-1:0] temp_i,
    output logic          sda_oe_o,
    output logic [DW-1:0] cfg_o,
    output logic [DW-1:0] tlo_o,
    output logic [DW-1:0] thi_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              wr_en;
    logic [1:0]        ptr;
    logic [DW-1:0]     wr_word, rd_word;

    assign raw_lines = {sda_i, scl_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        tsi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_LEN(VOTE_LEN)) i_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[i]), .filt_o(filt_lines[i])
        );
    end

    tsi_bus_ctrl #(.DW(DW), .ADDR_HI(ADDR_HI)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_f(filt_lines[0]), .sda_f(filt_lines[1]),
        .strap(strap_i), .rd_word(rd_word), .drive(sda_oe_o), .ptr(ptr),
        .wr_en(wr_en), .wr_word(wr_word)
    );

    tsi_regs #(.DW(DW), .CFG_RST(CFG_RST), .TLO_RST(TLO_RST), .THI_RST(THI_RST)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_word(wr_word),
        .temp_word(temp_i), .rd_word(rd_word), .cfg_q(cfg_o), .tlo_q(tlo_o), .thi_q(thi_o)
    );
endmodule

// File: tb/test_tsense_i2c_slave.sv
`timescale 1ns/1ps
module test_tsense_i2c_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic [15:0] temp = 16'h1910;
    logic        sda_oe, sda_line;
    logic [15:0] cfg_o, tlo_o, thi_o;
    int          n_chk = 0, n_fail = 0, oe_seen = 0;
    logic        mon_en = 1'b0;

    // Behavioural model of the register file.
    logic [15:0] m_reg [4];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tsense_i2c_slave i_tsense_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
        .temp_i(temp), .sda_oe_o(sda_oe), .cfg_o(cfg_o), .tlo_o(tlo_o), .thi_o(thi_o)
    );

    always @(negedge clk) if (mon_en && sda_oe) oe_seen++;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, input logic glitch, output logic seen);
        scl_m = 1'b0; wait_q(Q);
        sda_m = b;    wait_q(Q);
        scl_m = 1'b1; wait_q(Q/2);
        if (glitch && b) begin sda_m = 1'b0; wait_q(1); sda_m = 1'b1; wait_q(Q/2 - 1); end
        else wait_q(Q/2);
        seen = sda_line; wait_q(Q);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; wait_q(Q); sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q); sda_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wait_q(Q); sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q); sda_m = 1'b1; wait_q(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, input logic glitch, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], glitch, s);
        bit_cycle(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic nak, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, 1'b0, s); b[i] = s; end
        bit_cycle(nak, 1'b0, s);
    endtask

    // Full register write: address, pointer, n data bytes, STOP.
    task automatic do_write(input string tag, input logic [1:0] p, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic a;
        bus_start();
        wbyte({5'b10010, strap, 1'b0}, 1'b0, a); check({tag, " addr ack R3"}, a, 1);
        wbyte({6'b0, p}, 1'b0, a);               check({tag, " ptr ack R3"}, a, 1);
        if (n > 0) begin wbyte(d0, 1'b0, a); check({tag, " d0 ack R3"}, a, 1); end
        if (n > 1) begin wbyte(d1, 1'b0, a); check({tag, " d1 ack R3"}, a, 1); end
        if (n > 2) begin wbyte(d2, 1'b0, a); check({tag, " d2 ack R5"}, a, 1); end
        bus_stop();
        if (n >= 2 && p != 2'd0) m_reg[p] = {d0, d1};
    endtask

    task automatic do_read(input string tag, input logic [15:0] exp);
        logic a; logic [7:0] hi, lo;
        bus_start();
        wbyte({5'b10010, strap, 1'b1}, 1'b0, a); check({tag, " rd addr ack R3"}, a, 1);
        rbyte(1'b0, hi); rbyte(1'b1, lo);
        bus_stop();
        check({tag, " read word R7"}, {hi, lo}, exp);
    endtask

    task automatic check_regs(input string tag);
        check({tag, " cfg"}, cfg_o, m_reg[1]);
        check({tag, " tlo"}, tlo_o, m_reg[2]);
        check({tag, " thi"}, thi_o, m_reg[3]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a; logic [7:0] b;
        m_reg[0] = 16'h0; m_reg[1] = 16'h0000; m_reg[2] = 16'h4B00; m_reg[3] = 16'h5000;
        wait_q(6); rst_n = 1'b1; wait_q(10);

        // R1: reset state
        check("R1 sda_oe", sda_oe, 0);
        check_regs("R1");

        // R5: two-byte write to configuration
        do_write("R5 cfg", 2'd1, 2, 8'hAB, 8'hCD, 8'h00);
        check_regs("R5 cfg");
        // R7: read back, pointer kept from the write
        do_read("R7 cfg", 16'hABCD);

        // R2: wrong address is not acknowledged, later bytes ignored
        bus_start();
        wbyte(8'h90, 1'b0, a); check("R2 wrong addr no ack", a, 0);
        mon_en = 1'b1; oe_seen = 0;
        wbyte(8'h01, 1'b0, a); wbyte(8'h55, 1'b0, a); wbyte(8'h66, 1'b0, a);
        mon_en = 1'b0;
        bus_stop();
        check("R2 no drive after mismatch", oe_seen, 0);
        check_regs("R2");

        // R6 / R4: pointer-only write to the high limit, then a separate read
        do_write("R6 ptr only", 2'd3, 0, 8'h00, 8'h00, 8'h00);
        check_regs("R6");
        do_read("R4 thi", 16'h5000);
        do_write("R4 ptr lo", 2'd2, 0, 8'h00, 8'h00, 8'h00);
        do_read("R4 tlo", 16'h4B00);

        // R8: write to the read-only register is acked and ignored
        do_write("R8 temp", 2'd0, 2, 8'hFF, 8'hFF, 8'h00);
        check_regs("R8");
        do_read("R8 temp", 16'h1910);
        temp = 16'h0C80;
        do_read("R8 temp follows input", 16'h0C80);

        // R5: third data byte acked and discarded
        do_write("R5 thi", 2'd3, 3, 8'h11, 8'h22, 8'h33);
        check_regs("R5 thi");

        // R10: STOP after one data byte leaves the low limit unchanged
        bus_start();
        wbyte({5'b10010, strap, 1'b0}, 1'b0, a); check("R10 addr ack", a, 1);
        wbyte(8'h02, 1'b0, a); check("R10 ptr ack", a, 1);
        wbyte(8'h77, 1'b0, a); check("R10 d0 ack", a, 1);
        bus_stop();
        check_regs("R10 aborted");
        // R10: repeated START right after the pointer byte, read uses new pointer
        bus_start();
        wbyte({5'b10010, strap, 1'b0}, 1'b0, a);
        wbyte(8'h03, 1'b0, a);
        bus_start();
        wbyte({5'b10010, strap, 1'b1}, 1'b0, a); check("R10 restart addr ack", a, 1);
        rbyte(1'b0, b); check("R10 restart hi byte", b, 8'h11);
        rbyte(1'b1, b); check("R10 restart lo byte", b, 8'h22);
        bus_stop();

        // R9: after NACK the block drives nothing while the host keeps clocking
        bus_start();
        wbyte({5'b10010, strap, 1'b1}, 1'b0, a);
        rbyte(1'b1, b); check("R9 first byte", b, 8'h11);
        mon_en = 1'b1; oe_seen = 0;
        rbyte(1'b1, b);
        mon_en = 1'b0;
        bus_stop();
        check("R9 released after nack", oe_seen, 0);
        check("R9 bus reads ones", b, 8'hFF);

        // R11: one-clock SDA glitches while SCL is high do not disturb a write
        bus_start();
        wbyte({5'b10010, strap, 1'b0}, 1'b0, a);
        wbyte(8'h01, 1'b0, a);
        wbyte(8'hF0, 1'b1, a); check("R11 glitched d0 ack", a, 1);
        wbyte(8'h5A, 1'b1, a); check("R11 glitched d1 ack", a, 1);
        bus_stop();
        m_reg[1] = 16'hF05A;
        check_regs("R11");

        // R2: another strap code moves the address
        strap = 2'b01;
        bus_start();
        wbyte(8'h94, 1'b0, a); check("R2 old address ignored", a, 0);
        bus_stop();
        bus_start();
        wbyte(8'h92, 1'b0, a); check("R2 strap 01 ack", a, 1);
        wbyte(8'h01, 1'b0, a);
        bus_stop();
        do_read("R2 strap 01", 16'hF05A);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule